// File: doc/BRIEF.md
# Random Number Generator Control and Status Front End

This block is the register-facing side of a random number generator. A simple 32-bit register bus carries single-cycle reads and writes. Software uses it to start two background operations, a generator seeding pass and a self-test pass, and to watch their progress. Each operation is modelled as a three-state sequence (idle, running, done). The running phase lasts a fixed, parameterised number of clock cycles. When a sequence reaches its done state, a single level interrupt output goes high unless completion interrupts are masked. Software lowers the interrupt again through the command register.

The block exposes an identification word, a command register, a control register holding mask and auto-seed settings, and a status word. The status word carries busy, ready and per-operation done flags, plus constant buffer-size and buffer-fill fields. A data register returns a fresh pseudo-random word on every read. The words come from a 32-bit linear feedback shift register. No true entropy source, statistical test or error reporting is present; the error flags read as zero.

Top module: `randgen_csr`

## Requirements
- R1: A read of offset 0x00 returns 0x1000_0240: type 1 in bits 31:28, major revision 0x2 in bits 15:8, minor revision 0x40 in bits 7:0, other bits zero.
- R2: A read of an offset other than 0x00, 0x04, 0x08, 0x0C and 0x14 returns zero. A write to 0x00, 0x0C, 0x14 or an unmapped offset changes no register state.
- R3: The control register at 0x08 holds mask-error (bit 6), mask-done (bit 5) and auto-seed (bit 4) as read/write bits. All its other bits read zero.
- R4: Writing the command register (0x04) with bit 1 starts a seed pass and with bit 0 starts a self-test pass. Reading 0x04 shows bit 1 or bit 0 only while that pass runs. A pass enters its done state DONE_DELAY cycles after the write edge. A start while the pass is already running restarts that delay.
- R5: A read of the status word at 0x0C returns the following: bits 15:12 = 5 and bits 11:8 = 5; bit 6 = 1; bit 5 = seed done; bit 4 = self-test done. Bit 1 (busy) is set while either pass runs, and otherwise bit 0 (ready) is set. All other bits are zero.
- R6: The irq output goes high in the same cycle that a pass enters done, when mask-done is clear. When mask-done is set, completion leaves irq unchanged.
- R7: A command write with bit 5 (clear error) or bit 4 (clear interrupt) set drives irq low on the next cycle. A completion in that same cycle takes precedence.
- R8: A command write with bit 6 (soft reset) returns both passes to idle and clears the three control bits. Start bits in the same write still take effect.
- R9: Each read of 0x14 returns the current generator word and then advances it. The first word after reset is 0xACE1_2468. The next word is x>>1 when bit 0 of x is 0, and (x>>1) XOR 0x8020_0003 otherwise.
- R10: Read data appears on bus_rdata with bus_rvalid high on the cycle after bus_rd is sampled. bus_rvalid is low otherwise.
- R11: After the synchronous reset, irq is low, both passes are idle and the control bits are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | High for one cycle when bus_rdata holds a read result |
| irq | output | 1 | Completion interrupt, level |

## Verification
A read strobe sampled at one edge produces its data and valid flag right after that edge. The bench therefore queues each expected word when it drives the strobe. The monitor compares the word at the falling edge that follows, which is the first point where it can be stable. A start command written at edge N makes the running bit visible to a read sampled at edge N+1. Completion and the interrupt appear right after edge N+DONE_DELAY. The bench counts falling edges from the write and checks that irq is still low one cycle before that edge and high just after it; the same counting is applied from the second write of a restart. Interrupt clearing is checked one falling edge after the clearing write.

// File: rtl/randgen_csr_pkg.sv
package randgen_csr_pkg;

  localparam int WORD_W = 32;

  // Register byte offsets
  localparam int OFF_IDENT  = 'h00;
  localparam int OFF_CMD    = 'h04;
  localparam int OFF_CTRL   = 'h08;
  localparam int OFF_STATUS = 'h0C;
  localparam int OFF_DATA   = 'h14;

  // Command bit positions; start bits are indexed by operation number
  localparam int CMD_SOFT_RST = 6;
  localparam int CMD_CLR_ERR  = 5;
  localparam int CMD_CLR_IRQ  = 4;

  // Control bit positions
  localparam int CTL_MASK_ERR  = 6;
  localparam int CTL_MASK_DONE = 5;
  localparam int CTL_AUTO_SEED = 4;

  // Operation numbering: also the command start bit and the status done bit offset
  localparam int OP_SELFTEST = 0;
  localparam int OP_SEED     = 1;
  localparam int NUM_OPS     = 2;

  // Status bit positions
  localparam int ST_READY     = 0;
  localparam int ST_BUSY      = 1;
  localparam int ST_DONE_BASE = 4;
  localparam int ST_SEED_AVL  = 6;
  localparam int ST_LEVEL_LSB = 8;
  localparam int ST_SIZE_LSB  = 12;

  // Identification fields
  localparam logic [3:0] ID_TYPE  = 4'h1;
  localparam logic [7:0] ID_MAJOR = 8'h02;
  localparam logic [7:0] ID_MINOR = 8'h40;

  typedef enum logic [1:0] {
    OPS_IDLE = 2'd0,
    OPS_RUN  = 2'd1,
    OPS_DONE = 2'd2
  } op_state_e;

endpackage

// File: rtl/randgen_op_seq.sv
module randgen_op_seq
  import randgen_csr_pkg::*;
#(
  parameter int DONE_DELAY = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic soft_clr,
  input  logic start,
  output logic running,
  output logic done,
  output logic finish_evt
);

  localparam int CNT_W = (DONE_DELAY < 2) ? 1 : $clog2(DONE_DELAY);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DONE_DELAY - 1);

  op_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;

  // Completion fires only when nothing overrides it in the same cycle
  assign finish_evt = (st_q == OPS_RUN) && (cnt_q == '0) && !start && !soft_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= OPS_IDLE;
      cnt_q <= '0;
    end else if (start) begin
      st_q  <= OPS_RUN;
      cnt_q <= CNT_LOAD;
    end else if (soft_clr) begin
      st_q  <= OPS_IDLE;
      cnt_q <= '0;
    end else if (st_q == OPS_RUN) begin
      if (cnt_q == '0) st_q <= OPS_DONE;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign running = (st_q == OPS_RUN);
  assign done    = (st_q == OPS_DONE);

  a_r4_start_runs: assert property (@(posedge clk) disable iff (rst)
    start |=> running);
  a_r4_expiry_done: assert property (@(posedge clk) disable iff (rst)
    (running && cnt_q == '0 && !start && !soft_clr) |=> done);
  a_r4_no_skip: assert property (@(posedge clk) disable iff (rst)
    (st_q == OPS_IDLE) |=> !done);
  a_r8_soft_idle: assert property (@(posedge clk) disable iff (rst)
    (soft_clr && !start) |=> (!running && !done));

endmodule

// File: rtl/randgen_lfsr.sv
module randgen_lfsr #(
  parameter int          WIDTH = 32,
  parameter logic [31:0] SEED  = 32'hACE1_2468,
  parameter logic [31:0] TAPS  = 32'h8020_0003
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [WIDTH-1:0] value
);

  localparam logic [WIDTH-1:0] SEED_W = SEED[WIDTH-1:0];
  localparam logic [WIDTH-1:0] TAPS_W = TAPS[WIDTH-1:0];

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] next_state;

  // Galois form, shifting toward bit 0
  assign next_state = state_q[0] ? ((state_q >> 1) ^ TAPS_W) : (state_q >> 1);

  always_ff @(posedge clk) begin
    if (rst)       state_q <= SEED_W;
    else if (step) state_q <= next_state;
  end

  assign value = state_q;

  a_r9_never_zero: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(state_q));

endmodule

// File: rtl/randgen_csr.sv
module randgen_csr
  import randgen_csr_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          DONE_DELAY = 16,
  parameter int          FIFO_WORDS = 5,
  parameter logic [31:0] LFSR_SEED  = 32'hACE1_2468
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              irq
);

  localparam logic [3:0]  FIFO_FIELD = 4'(FIFO_WORDS);
  localparam logic [31:0] IDENT_WORD = {ID_TYPE, 12'h000, ID_MAJOR, ID_MINOR};

  // Address decode
  logic hit_cmd, hit_ctrl, hit_status, hit_ident, hit_data;
  assign hit_ident  = (bus_addr == ADDR_W'(OFF_IDENT));
  assign hit_cmd    = (bus_addr == ADDR_W'(OFF_CMD));
  assign hit_ctrl   = (bus_addr == ADDR_W'(OFF_CTRL));
  assign hit_status = (bus_addr == ADDR_W'(OFF_STATUS));
  assign hit_data   = (bus_addr == ADDR_W'(OFF_DATA));

  logic wr_cmd, wr_ctrl, soft_rst, clr_req;
  assign wr_cmd   = bus_wr && hit_cmd;
  assign wr_ctrl  = bus_wr && hit_ctrl;
  assign soft_rst = wr_cmd && bus_wdata[CMD_SOFT_RST];
  assign clr_req  = wr_cmd && (bus_wdata[CMD_CLR_ERR] || bus_wdata[CMD_CLR_IRQ]);

  // Control register
  logic mask_err_q, mask_done_q, auto_seed_q;
  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      mask_err_q  <= 1'b0;
      mask_done_q <= 1'b0;
      auto_seed_q <= 1'b0;
    end else if (wr_ctrl) begin
      mask_err_q  <= bus_wdata[CTL_MASK_ERR];
      mask_done_q <= bus_wdata[CTL_MASK_DONE];
      auto_seed_q <= bus_wdata[CTL_AUTO_SEED];
    end
  end

  // Operation sequencers, one per operation; start bit g drives sequencer g
  logic [NUM_OPS-1:0] op_run, op_done, op_fin;
  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    randgen_op_seq #(.DONE_DELAY(DONE_DELAY)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .soft_clr  (soft_rst),
      .start     (wr_cmd && bus_wdata[g]),
      .running   (op_run[g]),
      .done      (op_done[g]),
      .finish_evt(op_fin[g])
    );
  end

  // Interrupt: completion sets, clear command lowers, completion wins
  logic irq_set;
  assign irq_set = (|op_fin) && !mask_done_q;
  always_ff @(posedge clk) begin
    if (rst)          irq <= 1'b0;
    else if (irq_set) irq <= 1'b1;
    else if (clr_req) irq <= 1'b0;
  end

  // Data generator
  logic [31:0] rnd_word;
  randgen_lfsr #(.WIDTH(WORD_W), .SEED(LFSR_SEED)) u_lfsr (
    .clk  (clk),
    .rst  (rst),
    .step (bus_rd && hit_data),
    .value(rnd_word)
  );

  // Read mux
  logic        any_run;
  logic [31:0] rd_mux;
  assign any_run = |op_run;
  always_comb begin
    rd_mux = '0;
    if (hit_ident) begin
      rd_mux = IDENT_WORD;
    end else if (hit_cmd) begin
      rd_mux[NUM_OPS-1:0] = op_run;
    end else if (hit_ctrl) begin
      rd_mux[CTL_MASK_ERR]  = mask_err_q;
      rd_mux[CTL_MASK_DONE] = mask_done_q;
      rd_mux[CTL_AUTO_SEED] = auto_seed_q;
    end else if (hit_status) begin
      rd_mux[ST_SIZE_LSB +: 4]               = FIFO_FIELD;
      rd_mux[ST_LEVEL_LSB +: 4]              = FIFO_FIELD;
      rd_mux[ST_SEED_AVL]                    = 1'b1;
      rd_mux[ST_DONE_BASE +: NUM_OPS]        = op_done;
      rd_mux[ST_BUSY]                        = any_run;
      rd_mux[ST_READY]                       = !any_run;
    end else if (hit_data) begin
      rd_mux = rnd_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= bus_rd ? rd_mux : '0;
    end
  end

  a_r6_irq_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past((|op_fin) && !mask_done_q));
  a_r6_masked_hold: assert property (@(posedge clk) disable iff (rst)
    ((|op_fin) && mask_done_q && !clr_req) |=> $stable(irq));
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !(|op_fin)) |=> !irq);
  a_r10_rvalid_on: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  a_r10_rvalid_off: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);
  a_r5_busy_xor_ready: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(bus_rd && hit_status)) |-> (bus_rdata[ST_BUSY] != bus_rdata[ST_READY]));

endmodule

// File: tb/randgen_csr_bench.sv
module randgen_csr_bench;

  localparam int DLY = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq;

  always #4 clk = ~clk;

  randgen_csr #(.ADDR_W(8), .DONE_DELAY(DLY), .FIFO_WORDS(5), .LFSR_SEED(32'hACE1_2468)) u_randgen_csr (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq(irq)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] model_rnd = 32'hACE1_2468;

  function automatic logic [31:0] rnd_next(input logic [31:0] x);
    return x[0] ? ((x >> 1) ^ 32'h8020_0003) : (x >> 1);
  endfunction

  task automatic note(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Monitor: compares each returned word against the scoreboard head
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        note(1'b0, "R10 unexpected rvalid", bus_rdata, 32'h0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        note(bus_rdata === e, t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    note(irq === e, t, {31'b0, irq}, {31'b0, e});
  endtask

  initial begin
    #(8 * 200000);
    note(1'b0, "watchdog expired", 32'h0, 32'h0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk_irq(1'b0, "R11 irq after reset");
    rd(8'h04, 32'h0, "R11 command idle");
    rd(8'h08, 32'h0, "R11 control zero");
    rd(8'h0C, 32'h0000_5541, "R5 idle status");
    // R1 identification
    rd(8'h00, 32'h1000_0240, "R1 ident word");
    // R2 unmapped and read-only
    rd(8'h10, 32'h0, "R2 unmapped read");
    rd(8'h3C, 32'h0, "R2 unmapped read high");
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h00, 32'h1000_0240, "R2 ident unchanged");
    rd(8'h0C, 32'h0000_5541, "R2 status unchanged");
    rd(8'h08, 32'h0, "R2 control untouched by stray writes");
    // R3 control
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, 32'h0000_0070, "R3 control all ones");
    wr(8'h08, 32'h0000_0010);
    rd(8'h08, 32'h0000_0010, "R3 auto-seed only");
    wr(8'h08, 32'h0);
    // R4/R6 seed pass
    wr(8'h04, 32'h0000_0002);
    repeat (DLY - 1) @(negedge clk);
    chk_irq(1'b0, "R6 irq not before delay");
    @(negedge clk);
    chk_irq(1'b1, "R6 irq at completion");
    rd(8'h04, 32'h0, "R4 command cleared after done");
    rd(8'h0C, 32'h0000_5561, "R5 seed done status");
    // R4 running readback and busy
    wr(8'h04, 32'h0000_0001);
    rd(8'h04, 32'h0000_0001, "R4 self-test running");
    rd(8'h0C, 32'h0000_5562, "R5 busy while running");
    repeat (DLY) @(negedge clk);
    rd(8'h0C, 32'h0000_5571, "R5 both done");
    // R7 clear interrupt
    wr(8'h04, 32'h0000_0010);
    chk_irq(1'b0, "R7 clear-interrupt lowers irq");
    // R6 masked completion
    wr(8'h08, 32'h0000_0020);
    wr(8'h04, 32'h0000_0001);
    repeat (DLY + 2) @(negedge clk);
    chk_irq(1'b0, "R6 masked completion");
    rd(8'h0C, 32'h0000_5571, "R5 done with mask");
    wr(8'h08, 32'h0);
    // R4 restart
    wr(8'h04, 32'h0000_0002);
    repeat (DLY / 2) @(negedge clk);
    wr(8'h04, 32'h0000_0002);
    repeat (DLY - 1) @(negedge clk);
    chk_irq(1'b0, "R4 restart extends delay");
    @(negedge clk);
    chk_irq(1'b1, "R4 restart completion");
    // R7 clear-error also lowers irq
    wr(8'h04, 32'h0000_0020);
    chk_irq(1'b0, "R7 clear-error lowers irq");
    // R8 soft reset
    wr(8'h08, 32'h0000_0070);
    wr(8'h04, 32'h0000_0003);
    wr(8'h04, 32'h0000_0040);
    rd(8'h04, 32'h0, "R8 passes idle");
    rd(8'h08, 32'h0, "R8 control cleared");
    rd(8'h0C, 32'h0000_5541, "R8 status idle");
    repeat (DLY + 2) @(negedge clk);
    chk_irq(1'b0, "R8 no completion after soft reset");
    // R8 soft reset with start in same write
    wr(8'h04, 32'h0000_0042);
    rd(8'h04, 32'h0000_0002, "R8 start survives soft reset");
    repeat (DLY) @(negedge clk);
    wr(8'h04, 32'h0000_0010);
    // R9 data words; write to data offset must not advance
    wr(8'h14, 32'h1234_5678);
    for (int i = 0; i < 6; i++) begin
      rd(8'h14, model_rnd, "R9 generator word");
      model_rnd = rnd_next(model_rnd);
    end
    rd(8'h0C, 32'h0000_5561, "R5 status after data reads");
    repeat (3) @(negedge clk);
    note(exp_q.size() == 0, "R10 all reads answered", exp_q.size(), 32'h0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule